// File: doc/BRIEF.md
# Three-Wire Serial Control Register Port

This block accepts 16-bit control words over a three-wire serial link (a data line, a shift clock and a latch strobe) and stores them in an on-chip register bank. Each word carries a 7-bit register address in its upper bits and 9 data bits in its lower bits. The register contents are driven out in parallel to the rest of the chip. Every committed word also produces a one-cycle write strobe together with the decoded address and data.

No frame start and no bit counter exist. The serial clock and the latch line are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. Each rising shift-clock edge pushes one bit into a 16-bit shift register. A rising latch edge commits whatever that shift register holds at that moment. A static mode input enables the port. When the mode input is low, the port ignores all serial traffic.

Top module: `ser3w_regport`

## Requirements
- R1: After reset every register in the bank reads zero and the write strobe is low.
- R2: Bits arrive most-significant first. In the committed word, bits 15..9 are the register address and bits 8..0 are the data, and that data is written into the register at that address.
- R3: Only a rising shift-clock edge moves a bit in. A shift clock held high for many system cycles, or a falling edge, shifts nothing further.
- R4: Only a rising latch edge commits a word. Holding the latch high or letting it fall produces no further write.
- R5: When more than 16 shift edges come before a latch edge, the word committed is formed from the last 16 bits received.
- R6: The shift register is not cleared by a commit. When fewer than 16 bits arrive before a latch edge, the upper bits of the committed word are the older contents, shifted up.
- R7: Each latch rising edge gives exactly one strobe pulse, one system cycle wide, with the committed address and data on the write outputs.
- R8: A write changes only the addressed register. Every other register keeps its value.
- R9: An address at or above the bank depth (64) changes no register, yet the strobe still pulses with that address.
- R10: While the mode input is low, shift and latch edges are ignored. No strobe occurs, no register changes, and the shift register keeps its contents.
- R11: The strobe is high after the third system clock rising edge following the latch pin going high. The bank output shows the new value one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wire3_sel | input | 1 | 1 = three-wire port enabled (static configuration) |
| sdat_i | input | 1 | Serial data, sampled on shift-clock rise |
| sclk_i | input | 1 | Serial shift clock, asynchronous to clk |
| latch_i | input | 1 | Latch strobe; rising edge commits a word |
| reg_flat_o | output | 576 | Register bank, entry i at bits [9*i+8 : 9*i] |
| wr_stb_o | output | 1 | One-cycle pulse per committed word |
| wr_addr_o | output | 7 | Address of the committed word |
| wr_data_o | output | 9 | Data of the committed word |

## Verification
When the latch pin rises, the strobe is due after the third system edge and the register output after the fourth. The latch task counts falling clock edges from the moment it drives the pin and records the edge where the strobe first appears. It then waits several more cycles before reading any register. Serial bits are held for several system cycles on each phase of the shift clock. This keeps every bit well clear of the two-cycle synchronizer delay. A falling-edge monitor counts strobes and captures the address and data on them, so that missing or extra pulses are caught.

// File: rtl/ser3w_pkg.sv
// Package: default geometry for the three-wire control port.
// Assumes: address width large enough to cover the bank depth.
package ser3w_pkg;
    localparam int ADDR_W_DEF = 7;
    localparam int DATA_W_DEF = 9;
    localparam int DEPTH_DEF  = 64;
    localparam int SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/ser3w_sync.sv
// Module: multi-bit flop-chain synchronizer. Each bit is independent.
// Assumes: inputs are quasi-static levels; STAGES >= 2.
module ser3w_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] st_q [STAGES];

    // Chain the asynchronous level through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
        end else begin
            st_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
        end
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ser3w_edge.sv
// Module: rising-edge detector on synchronized levels.
// Assumes: inputs already in the clk domain.
module ser3w_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // Remember last level to find 0->1 transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

    // R3/R4: a detected rise never lasts two cycles in a row.
    a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        |rise_o |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/ser3w_shifter.sv
// Module: MSB-first serial-in shift register, never cleared by a commit.
// Assumes: shift_en is a single-cycle pulse per shift-clock rise.
module ser3w_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] sh_q;

    // Shift one bit in at the LSB; oldest bits fall off the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)        sh_q <= '0;
        else if (shift_en) sh_q <= {sh_q[WORD_W-2:0], bit_i};
    end

    assign word_o = sh_q;

    // R3/R10: contents hold when no shift is requested.
    a_r3_hold_without_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sh_q));
endmodule

// File: rtl/ser3w_regbank.sv
// Module: register bank written by address/data strobes, flattened output.
// Assumes: DEPTH <= 2**ADDR_W; addresses >= DEPTH are dropped.
module ser3w_regbank #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 9,
    parameter int DEPTH  = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DEPTH*DATA_W-1:0] flat_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] regs_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Load entry i when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   regs_q[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))      regs_q[i] <= wr_data;
        end
        assign flat_o[i*DATA_W +: DATA_W] = regs_q[i];
    end

    logic in_range;
    assign in_range = (32'(wr_addr) < 32'(DEPTH));

    // R8: an in-range write lands in the addressed entry.
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_range) |=> regs_q[$past(wr_addr[IDX_W-1:0])] == $past(wr_data));

    // R9: an out-of-range write leaves the whole bank untouched.
    a_r9_oor_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_range) |=> $stable(flat_o));

    // R10: no strobe, no change.
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flat_o));
endmodule

// File: rtl/ser3w_regport.sv
// Module: top of the three-wire control port. Synchronizes the serial pins,
// shifts on shift-clock rise, commits on latch rise, writes the bank.
// Assumes: wire3_sel is static while traffic is in flight; serial phases
// last longer than the synchronizer delay.
module ser3w_regport
    import ser3w_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int DEPTH  = DEPTH_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wire3_sel,
    input  logic                    sdat_i,
    input  logic                    sclk_i,
    input  logic                    latch_i,
    output logic [DEPTH*DATA_W-1:0] reg_flat_o,
    output logic                    wr_stb_o,
    output logic [ADDR_W-1:0]       wr_addr_o,
    output logic [DATA_W-1:0]       wr_data_o
);
    localparam int WORD_W = ADDR_W + DATA_W;

    logic [2:0]        pins_s;
    logic [1:0]        rise;
    logic              shift_en, commit;
    logic [WORD_W-1:0] word;
    logic              stb_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    ser3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({sdat_i, sclk_i, latch_i}), .q_o(pins_s)
    );

    ser3w_edge #(.W(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(pins_s[1:0]), .rise_o(rise)
    );

    assign shift_en = rise[1] & wire3_sel;
    assign commit   = rise[0] & wire3_sel;

    ser3w_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .bit_i(pins_s[2]), .word_o(word)
    );

    // Register the committed word and a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            stb_q <= commit;
            if (commit) begin
                addr_q <= word[WORD_W-1:DATA_W];
                data_q <= word[DATA_W-1:0];
            end
        end
    end

    ser3w_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(stb_q),
        .wr_addr(addr_q), .wr_data(data_q), .flat_o(reg_flat_o)
    );

    assign wr_stb_o  = stb_q;
    assign wr_addr_o = addr_q;
    assign wr_data_o = data_q;

    // R7: strobe is exactly one cycle wide.
    a_r7_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R10: no strobe unless the port was enabled when it committed.
    a_r10_stb_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> $past(wire3_sel));

    // R7: write outputs hold between strobes.
    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_o |=> (wr_stb_o || ($stable(wr_addr_o) && $stable(wr_data_o))));
endmodule

// File: tb/ser3w_regport_tb.sv
module ser3w_regport_tb_top;
    localparam int CLK_PER = 10;
    localparam int AW = 7;
    localparam int DW = 9;
    localparam int DEP = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wire3_sel = 1'b1;
    logic sdat = 1'b0, sclk = 1'b0, latch = 1'b0;
    logic [DEP*DW-1:0] flat;
    logic wr_stb;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int n_chk = 0, n_err = 0;
    int stb_cnt = 0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;
    logic [15:0] shadow = '0;  // bench model of the shift register

    always #(CLK_PER/2) clk = ~clk;

    ser3w_regport dut_i (
        .clk(clk), .rst_n(rst_n), .wire3_sel(wire3_sel),
        .sdat_i(sdat), .sclk_i(sclk), .latch_i(latch),
        .reg_flat_o(flat), .wr_stb_o(wr_stb),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) if (rst_n && wr_stb) begin
        stb_cnt++;
        last_addr = wr_addr;
        last_data = wr_data;
    end

    function automatic logic [DW-1:0] rd(input int a);
        return flat[a*DW +: DW];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] v, input int n, input int hold);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = v[i];
            repeat (hold) @(negedge clk);
            sclk = 1'b1;
            repeat (hold) @(negedge clk);
            sclk = 1'b0;
            if (wire3_sel) shadow = {shadow[14:0], v[i]};
        end
        repeat (hold) @(negedge clk);
    endtask

    task automatic pulse_latch(output int lat);
        lat = -1;
        latch = 1'b1;
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            if (wr_stb && lat < 0) lat = c;
        end
        latch = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_word(input logic [6:0] a, input logic [8:0] d);
        int lat;
        send_bits({16'h0, a, d}, 16, 2);
        pulse_latch(lat);
    endtask

    task automatic t_reset;
        bit allz = 1'b1;
        for (int a = 0; a < DEP; a++) if (rd(a) != '0) allz = 1'b0;
        chk(allz, "R1 bank zero", 32'(allz), 1);
        chk(wr_stb == 1'b0 && stb_cnt == 0, "R1 strobe low", 32'(stb_cnt), 0);
    endtask

    task automatic t_basic_latency;
        int lat, c0;
        logic [DW-1:0] r6;
        c0 = stb_cnt;
        r6 = rd(6);
        send_bits({16'h0, 7'd5, 9'h1A5}, 16, 2);
        latch = 1'b1;
        lat = -1;
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            if (wr_stb && lat < 0) lat = c;
            if (c == 3) chk(rd(5) == '0, "R11 bank not yet updated", 32'(rd(5)), 0);
        end
        latch = 1'b0;
        repeat (4) @(negedge clk);
        chk(lat == 3, "R11 strobe latency", 32'(lat), 3);
        chk(rd(5) == 9'h1A5, "R2 reg5 written", 32'(rd(5)), 32'h1A5);
        chk(last_addr == 7'd5 && last_data == 9'h1A5, "R7 strobe addr/data",
            {16'(last_addr), 16'(last_data)}, {16'd5, 16'h1A5});
        chk(stb_cnt == c0 + 1, "R7 one strobe", 32'(stb_cnt - c0), 1);
        chk(rd(6) == r6, "R8 neighbour unchanged", 32'(rd(6)), 32'(r6));
    endtask

    task automatic t_patterns;
        write_word(7'd63, 9'h0FF);
        write_word(7'd0, 9'h100);
        chk(rd(63) == 9'h0FF, "R2 reg63", 32'(rd(63)), 32'h0FF);
        chk(rd(0) == 9'h100, "R2 reg0", 32'(rd(0)), 32'h100);
        chk(rd(5) == 9'h1A5, "R8 reg5 kept", 32'(rd(5)), 32'h1A5);
    endtask

    task automatic t_slow_clock;  // R3: long high phases shift once per rise
        int lat;
        send_bits({16'h0, 7'd20, 9'h0C3}, 16, 12);
        pulse_latch(lat);
        chk(rd(20) == 9'h0C3, "R3 slow shift clock", 32'(rd(20)), 32'h0C3);
    endtask

    task automatic t_overflow;
        int lat;
        send_bits({12'h0, 4'hA, 7'd10, 9'h055}, 20, 2);
        pulse_latch(lat);
        chk(rd(10) == 9'h055, "R5 last 16 bits kept", 32'(rd(10)), 32'h055);
        chk(last_addr == 7'd10, "R5 address", 32'(last_addr), 10);
    endtask

    task automatic t_partial;
        int lat;
        logic [15:0] exp;
        write_word(7'd1, 9'h0F3);
        send_bits(32'h5, 4, 2);
        exp = shadow;
        pulse_latch(lat);
        chk(last_addr == exp[15:9] && last_data == exp[8:0], "R6 stale upper bits",
            {16'(last_addr), 16'(last_data)}, {16'(exp[15:9]), 16'(exp[8:0])});
        chk(rd(int'(exp[15:9])) == exp[8:0], "R6 register", 32'(rd(int'(exp[15:9]))), 32'(exp[8:0]));
    endtask

    task automatic t_oor;
        logic [DEP*DW-1:0] snap;
        int c0;
        snap = flat;
        c0 = stb_cnt;
        write_word(7'd100, 9'h1FF);
        chk(flat == snap, "R9 bank unchanged", 32'(flat != snap), 0);
        chk(stb_cnt == c0 + 1 && last_addr == 7'd100, "R9 strobe still pulses",
            32'(last_addr), 100);
    endtask

    task automatic t_latch_level;
        int c0;
        send_bits({16'h0, 7'd33, 9'h12E}, 16, 2);
        c0 = stb_cnt;
        latch = 1'b1;
        repeat (30) @(negedge clk);
        latch = 1'b0;
        repeat (10) @(negedge clk);
        chk(stb_cnt == c0 + 1, "R4 one write per rise", 32'(stb_cnt - c0), 1);
        chk(rd(33) == 9'h12E, "R4 committed value", 32'(rd(33)), 32'h12E);
    endtask

    task automatic t_mode_off;
        int lat, c0;
        logic [15:0] keep;
        logic [DW-1:0] r3;
        keep = shadow;
        r3 = rd(3);
        c0 = stb_cnt;
        wire3_sel = 1'b0;
        repeat (3) @(negedge clk);
        send_bits({16'h0, 7'd3, 9'h111}, 16, 2);
        pulse_latch(lat);
        chk(stb_cnt == c0, "R10 no strobe when off", 32'(stb_cnt - c0), 0);
        chk(rd(3) == r3, "R10 register unchanged", 32'(rd(3)), 32'(r3));
        wire3_sel = 1'b1;
        repeat (3) @(negedge clk);
        pulse_latch(lat);
        chk(last_addr == keep[15:9] && last_data == keep[8:0], "R10 shifter kept",
            {16'(last_addr), 16'(last_data)}, {16'(keep[15:9]), 16'(keep[8:0])});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic_latency();
        t_patterns();
        t_slow_clock();
        t_overflow();
        t_partial();
        t_oor();
        t_latch_level();
        t_mode_off();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule